// File: doc/BRIEF.md
# Scatter-Gather Region Table Walker

This block is the data-movement core of a bus-master storage DMA engine. Software places a table of 8-byte region entries in memory. Each entry names a host buffer and its size. The walker reads the entries one at a time over a simple read port. It then moves the device's pending bytes into or out of those buffers by issuing memory burst commands, each with an address, a length and a direction.

A fresh transfer is launched with `start`, which rewinds to the table base. A follow-on transfer is launched with `resume`, which keeps the table pointer and whatever is left of the current region. This lets one disk command be served in several pieces.

Each transfer ends with a one-cycle `done` pulse and a result code. The code reports one of three outcomes:
- every pending byte was placed;
- the table ran out first;
- `active` was withdrawn.

Top module: `prd_walker`

## Requirements
- R1: After reset, `busy`, `done`, `desc_req` and `burst_valid` are all low, and `busy` low implies no request is raised.
- R2: A returned entry is little-endian. `desc_rdata[31:0]` is the region base address. The region byte count is control-word bits 15:1 (that is, `desc_rdata[47:33]`) times two, so control bit 0 is ignored. Control bit 31 (`desc_rdata[63]`) flags the final entry.
- R3: A decoded byte count of zero stands for a 65536-byte region.
- R4: Entry reads start at `table_base` and step by 8 bytes per read. `desc_req` and `desc_addr` hold until `desc_rvalid`.
- R5: A new entry is read only when the current region's remaining count is zero. After `resume`, the next burst continues in the current region, at its base plus the bytes already used.
- R6: Each burst length is the smaller of the pending device bytes and the region's remaining bytes; it is never 0 and never above 65536. `burst_write` equals the `dir` captured at start or resume (1 = device to memory).
- R7: When the region is exhausted and was flagged final while bytes remain pending, the walk ends with result 1 (table exhausted).
- R8: No entry is read once the read pointer is `PAGE_BYTES` or more past `table_base`; the walk then ends with result 1.
- R9: When pending bytes reach zero, the walk ends with result 0 (complete), without reading further entries.
- R10: With `active` low, no new entry read or burst begins after the access in progress finishes. The walk ends with result 2 (stopped).
- R11: `done` is a single-cycle pulse and `result` never shows code 3.
- R12: A burst command holds its address and length until `burst_ready`. `desc_req` and `burst_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer from the table base (idle only) |
| resume | input | 1 | Continue the walk with a new pending count (idle only) |
| active | input | 1 | Engine enable; low stops the walk at the next step |
| dir | input | 1 | 1 = device to memory (write), 0 = memory to device |
| table_base | input | 32 | Byte address of the region table |
| xfer_len | input | LEN_W | Device bytes pending for this transfer |
| desc_req | output | 1 | Entry read request |
| desc_addr | output | 32 | Entry read address |
| desc_rvalid | input | 1 | Entry read data valid |
| desc_rdata | input | 64 | Entry read data |
| burst_valid | output | 1 | Burst command valid |
| burst_ready | input | 1 | Burst command accepted |
| burst_addr | output | 32 | Burst start address |
| burst_len | output | 17 | Burst length in bytes |
| burst_write | output | 1 | Burst direction, 1 = write memory |
| burst_done | input | 1 | Pulse: the accepted burst has moved its bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | 2 | 0 complete, 1 table exhausted, 2 stopped |

## Verification
The bench builds the walker with its defaults: `LEN_W` of 24 and `PAGE_BYTES` of 4096.

The 24-bit pending count lets a transfer exceed 65536 bytes. This brings the zero-count (64 KiB) region and the exhausted result together in one run.

With a 4096-byte page, a table of 512 unterminated two-byte entries reaches the page guard in a few thousand cycles. This makes the cap observable at the ports.

The resume sequence exercises region state carried across transfers.

// File: rtl/prd_pkg.sv
package prd_pkg;

    localparam int unsigned PRD_ADDR_W  = 32;
    localparam int unsigned PRD_CNT_W   = 17;
    localparam int unsigned PRD_ENTRY_B = 8;

    typedef enum logic [2:0] {
        WALK_IDLE  = 3'd0,
        WALK_CHECK = 3'd1,
        WALK_FETCH = 3'd2,
        WALK_ISSUE = 3'd3,
        WALK_WAIT  = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        RES_COMPLETE  = 2'd0,
        RES_EXHAUSTED = 2'd1,
        RES_STOPPED   = 2'd2
    } walk_result_e;

endpackage

// File: rtl/prd_entry_decode.sv
module prd_entry_decode
    import prd_pkg::*;
(
    input  logic [63:0]            entry,
    output logic [PRD_ADDR_W-1:0]  region_addr,
    output logic [PRD_CNT_W-1:0]   region_len,
    output logic                   region_final
);
    logic [14:0] half_count;
    logic        unused_rsvd;

    assign half_count   = entry[47:33];
    assign region_addr  = entry[PRD_ADDR_W-1:0];
    assign region_final = entry[63];
    assign unused_rsvd  = ^{entry[62:48], entry[32]};

    always_comb begin
        if (half_count == '0) begin
            region_len = PRD_CNT_W'(1) << 16;
        end else begin
            region_len = {1'b0, half_count, 1'b0};
        end
    end
endmodule

// File: rtl/prd_chunk_sizer.sv
module prd_chunk_sizer
    import prd_pkg::*;
#(
    parameter int unsigned LEN_W = 24
) (
    input  logic [LEN_W-1:0]     pending,
    input  logic [PRD_CNT_W-1:0] region_left,
    output logic [PRD_CNT_W-1:0] chunk
);
    localparam int unsigned CMP_W = (LEN_W > PRD_CNT_W) ? LEN_W : PRD_CNT_W;

    logic [CMP_W-1:0] pend_w;
    logic [CMP_W-1:0] left_w;

    assign pend_w = CMP_W'(pending);
    assign left_w = CMP_W'(region_left);

    always_comb begin
        if (pend_w < left_w) begin
            chunk = PRD_CNT_W'(pend_w);
        end else begin
            chunk = region_left;
        end
    end
endmodule

// File: rtl/prd_page_guard.sv
module prd_page_guard
    import prd_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic [PRD_ADDR_W-1:0] table_base,
    input  logic [PRD_ADDR_W-1:0] read_ptr,
    output logic                  over_page
);
    logic [PRD_ADDR_W-1:0] span;

    assign span      = read_ptr - table_base;
    assign over_page = (span >= PRD_ADDR_W'(PAGE_BYTES));
endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prd_pkg::*;
#(
    parameter int unsigned LEN_W      = 24,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  resume,
    input  logic                  active,
    input  logic                  dir,
    input  logic [31:0]           table_base,
    input  logic [LEN_W-1:0]      xfer_len,
    output logic                  desc_req,
    output logic [31:0]           desc_addr,
    input  logic                  desc_rvalid,
    input  logic [63:0]           desc_rdata,
    output logic                  burst_valid,
    input  logic                  burst_ready,
    output logic [31:0]           burst_addr,
    output logic [16:0]           burst_len,
    output logic                  burst_write,
    input  logic                  burst_done,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            result
);
    localparam logic [PRD_ADDR_W-1:0] STEP = PRD_ADDR_W'(PRD_ENTRY_B);

    typedef struct packed {
        walk_state_e             st;
        logic [PRD_ADDR_W-1:0]   base;
        logic [PRD_ADDR_W-1:0]   ptr;
        logic [PRD_ADDR_W-1:0]   raddr;
        logic [PRD_CNT_W-1:0]    rlen;
        logic                    rfinal;
        logic [LEN_W-1:0]        pend;
        logic                    wr;
        logic                    fin;
        walk_result_e            res;
    } walk_t;

    walk_t cur_q;
    walk_t nxt_d;

    logic [PRD_ADDR_W-1:0] dec_addr;
    logic [PRD_CNT_W-1:0]  dec_len;
    logic                  dec_final;
    logic [PRD_CNT_W-1:0]  chunk;
    logic                  page_over;

    prd_entry_decode u_decode (
        .entry        (desc_rdata),
        .region_addr  (dec_addr),
        .region_len   (dec_len),
        .region_final (dec_final)
    );

    prd_chunk_sizer #(.LEN_W(LEN_W)) u_sizer (
        .pending     (cur_q.pend),
        .region_left (cur_q.rlen),
        .chunk       (chunk)
    );

    prd_page_guard #(.PAGE_BYTES(PAGE_BYTES)) u_guard (
        .table_base (cur_q.base),
        .read_ptr   (cur_q.ptr),
        .over_page  (page_over)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.fin = 1'b0;
        case (cur_q.st)
            WALK_IDLE: begin
                if (start) begin
                    nxt_d.st     = WALK_CHECK;
                    nxt_d.base   = table_base;
                    nxt_d.ptr    = table_base;
                    nxt_d.raddr  = '0;
                    nxt_d.rlen   = '0;
                    nxt_d.rfinal = 1'b0;
                    nxt_d.pend   = xfer_len;
                    nxt_d.wr     = dir;
                end else if (resume) begin
                    nxt_d.st   = WALK_CHECK;
                    nxt_d.pend = xfer_len;
                    nxt_d.wr   = dir;
                end
            end
            WALK_CHECK: begin
                if (cur_q.pend == '0) begin
                    nxt_d.st  = WALK_IDLE;
                    nxt_d.fin = 1'b1;
                    nxt_d.res = RES_COMPLETE;
                end else if (!active) begin
                    nxt_d.st  = WALK_IDLE;
                    nxt_d.fin = 1'b1;
                    nxt_d.res = RES_STOPPED;
                end else if (cur_q.rlen == '0) begin
                    if (cur_q.rfinal || page_over) begin
                        nxt_d.st  = WALK_IDLE;
                        nxt_d.fin = 1'b1;
                        nxt_d.res = RES_EXHAUSTED;
                    end else begin
                        nxt_d.st = WALK_FETCH;
                    end
                end else begin
                    nxt_d.st = WALK_ISSUE;
                end
            end
            WALK_FETCH: begin
                if (desc_rvalid) begin
                    nxt_d.st     = WALK_CHECK;
                    nxt_d.raddr  = dec_addr;
                    nxt_d.rlen   = dec_len;
                    nxt_d.rfinal = dec_final;
                    nxt_d.ptr    = cur_q.ptr + STEP;
                end
            end
            WALK_ISSUE: begin
                if (burst_ready) begin
                    nxt_d.st = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (burst_done) begin
                    nxt_d.st    = WALK_CHECK;
                    nxt_d.raddr = cur_q.raddr + PRD_ADDR_W'(chunk);
                    nxt_d.rlen  = cur_q.rlen - chunk;
                    nxt_d.pend  = cur_q.pend - LEN_W'(chunk);
                end
            end
            default: begin
                nxt_d.st = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: WALK_IDLE, base: '0, ptr: '0, raddr: '0, rlen: '0,
                       rfinal: 1'b0, pend: '0, wr: 1'b0, fin: 1'b0,
                       res: RES_COMPLETE};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign desc_req    = (cur_q.st == WALK_FETCH);
    assign desc_addr   = cur_q.ptr;
    assign burst_valid = (cur_q.st == WALK_ISSUE);
    assign burst_addr  = cur_q.raddr;
    assign burst_len   = chunk;
    assign burst_write = cur_q.wr;
    assign busy        = (cur_q.st != WALK_IDLE);
    assign done        = cur_q.fin;
    assign result      = cur_q.res;
endmodule

// File: rtl/prd_walker_checks.sv
module prd_walker_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        desc_req,
    input logic [31:0] desc_addr,
    input logic        desc_rvalid,
    input logic        burst_valid,
    input logic        burst_ready,
    input logic [31:0] burst_addr,
    input logic [16:0] burst_len,
    input logic        done,
    input logic [1:0]  result
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!desc_req && !burst_valid));

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_req, burst_valid}));

    a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_valid && !burst_ready) |=>
            (burst_valid && $stable(burst_addr) && $stable(burst_len)));

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && !desc_rvalid) |=> (desc_req && $stable(desc_addr)));

    a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_len != 17'd0 && burst_len <= 17'h10000));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_result_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result != 2'd3));
endmodule

bind prd_walker prd_walker_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .desc_req    (desc_req),
    .desc_addr   (desc_addr),
    .desc_rvalid (desc_rvalid),
    .burst_valid (burst_valid),
    .burst_ready (burst_ready),
    .burst_addr  (burst_addr),
    .burst_len   (burst_len),
    .done        (done),
    .result      (result)
);

// File: tb/prd_walker_test.sv
module prd_walker_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 24;
    localparam int NTBL       = 520;
    localparam logic [31:0] TBASE = 32'h1000_0000;

    typedef struct packed {
        logic [31:0] len;
        logic        dir;
        logic [31:0] c0;
        logic [31:0] c1;
        logic [31:0] c2;
        logic [1:0]  res;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{len: 32'd100,   dir: 1'b1, c0: 32'h8000_0200, c1: 32'h0, c2: 32'h0, res: 2'd0},
        '{len: 32'd1000,  dir: 1'b0, c0: 32'h0000_0101, c1: 32'h8000_0400, c2: 32'h0, res: 2'd0},
        '{len: 32'd3000,  dir: 1'b1, c0: 32'h0000_0200, c1: 32'h8000_0300, c2: 32'h0, res: 2'd1},
        '{len: 32'd70000, dir: 1'b1, c0: 32'h8000_0000, c1: 32'h0, c2: 32'h0, res: 2'd1},
        '{len: 32'd512,   dir: 1'b0, c0: 32'h0000_0100, c1: 32'h0000_0100, c2: 32'h8000_0100, res: 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, resume = 1'b0, active = 1'b1, dir = 1'b0;
    logic [31:0] table_base = TBASE;
    logic [LEN_W-1:0] xfer_len = '0;
    logic desc_req, desc_rvalid = 1'b0;
    logic [31:0] desc_addr;
    logic [63:0] desc_rdata = '0;
    logic burst_valid, burst_ready = 1'b0, burst_write, burst_done = 1'b0;
    logic [31:0] burst_addr;
    logic [16:0] burst_len;
    logic busy, done;
    logic [1:0] result;

    prd_walker #(.LEN_W(LEN_W), .PAGE_BYTES(4096)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .active(active),
        .dir(dir), .table_base(table_base), .xfer_len(xfer_len),
        .desc_req(desc_req), .desc_addr(desc_addr), .desc_rvalid(desc_rvalid),
        .desc_rdata(desc_rdata), .burst_valid(burst_valid), .burst_ready(burst_ready),
        .burst_addr(burst_addr), .burst_len(burst_len), .burst_write(burst_write),
        .burst_done(burst_done), .busy(busy), .done(done), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [63:0] tbl [NTBL];
    logic [31:0] f_log [NTBL];
    logic [31:0] b_addr [NTBL];
    logic [16:0] b_len [NTBL];
    logic        b_wr [NTBL];
    int nf = 0, nb = 0;
    logic [31:0] cap_addr;
    logic [16:0] cap_len;
    logic        cap_wr;
    logic        stall = 1'b0;

    int e_nf, e_nb;
    logic [31:0] e_f [NTBL];
    logic [31:0] e_ba [NTBL];
    int          e_bl [NTBL];
    logic [31:0] m_base, m_ptr, m_raddr;
    int          m_rlen;
    logic        m_final;

    int n_chk = 0, n_err = 0;

    // entry read responder, one cycle latency
    always @(negedge clk) begin
        if (desc_rvalid) begin
            desc_rvalid <= 1'b0;
        end else if (rst_n && desc_req) begin
            desc_rvalid <= 1'b1;
            desc_rdata  <= (((desc_addr - TBASE) >> 3) < NTBL) ?
                           tbl[(desc_addr - TBASE) >> 3] : 64'h0;
            if (nf < NTBL) f_log[nf] <= desc_addr;
            nf <= nf + 1;
        end
    end

    // burst responder: accepts every other offered cycle, completes next cycle
    always @(negedge clk) begin
        if (burst_done) burst_done <= 1'b0;
        if (burst_ready) begin
            burst_ready <= 1'b0;
            burst_done  <= 1'b1;
            if (nb < NTBL) begin
                b_addr[nb] <= cap_addr;
                b_len[nb]  <= cap_len;
                b_wr[nb]   <= cap_wr;
            end
            nb <= nb + 1;
        end else if (rst_n && burst_valid && !burst_done) begin
            stall <= ~stall;
            if (stall) begin
                burst_ready <= 1'b1;
                cap_addr    <= burst_addr;
                cap_len     <= burst_len;
                cap_wr      <= burst_write;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference walk built from the requirements
    task automatic model_run(input int pend, input bit fresh);
        e_nf = 0;
        e_nb = 0;
        if (fresh) begin
            m_base = TBASE; m_ptr = TBASE; m_raddr = 0; m_rlen = 0; m_final = 0;
        end
        while (pend != 0) begin
            if (m_rlen == 0) begin
                logic [63:0] w;
                if (m_final || (m_ptr - m_base) >= 32'd4096) break;
                w = tbl[(m_ptr - m_base) >> 3];
                e_f[e_nf] = m_ptr;
                e_nf++;
                m_ptr   = m_ptr + 8;
                m_raddr = w[31:0];
                m_rlen  = int'(w[47:33]) * 2;
                if (m_rlen == 0) m_rlen = 65536;
                m_final = w[63];
            end else begin
                int c;
                c = (pend < m_rlen) ? pend : m_rlen;
                e_ba[e_nb] = m_raddr;
                e_bl[e_nb] = c;
                e_nb++;
                m_raddr = m_raddr + c;
                m_rlen  = m_rlen - c;
                pend    = pend - c;
            end
        end
    endtask

    task automatic run_walk(input int len, input bit fresh, input bit d,
                            input logic [1:0] exp_res, input bit drop);
        bit got;
        got = 0;
        if (!drop) model_run(len, fresh);
        @(negedge clk);
        nf = 0;
        nb = 0;
        xfer_len = LEN_W'(len);
        dir = d;
        active = 1'b1;
        start = fresh;
        resume = !fresh;
        @(negedge clk);
        start = 1'b0;
        resume = 1'b0;
        for (int i = 0; i < 20000 && !got; i++) begin
            if (done) got = 1;
            else begin
                @(negedge clk);
                if (drop && nb >= 1) active = 1'b0;
            end
        end
        chk(got, "R11 done seen", got, 1);
        chk(result == exp_res, "R7/R9/R10 result", result, exp_res);
        if (!drop) begin
            chk(nf == e_nf, "R4/R5 entry read count", nf, e_nf);
            for (int i = 0; i < e_nf && i < nf; i++)
                chk(f_log[i] == e_f[i], "R4 read address", f_log[i], e_f[i]);
            chk(nb == e_nb, "R6 burst count", nb, e_nb);
            for (int i = 0; i < e_nb && i < nb; i++) begin
                chk(b_addr[i] == e_ba[i], "R5 burst address", b_addr[i], e_ba[i]);
                chk(int'(b_len[i]) == e_bl[i], "R6 burst length", b_len[i], e_bl[i]);
                chk(b_wr[i] == d, "R6 burst direction", b_wr[i], d);
            end
        end
        @(negedge clk);
        chk(!done && !busy, "R11 single pulse", done, 0);
    endtask

    task automatic clear_tbl();
        for (int i = 0; i < NTBL; i++) tbl[i] = 64'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        clear_tbl();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !desc_req && !burst_valid, "R1 reset state",
            {busy, done, desc_req, burst_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !desc_req && !burst_valid, "R1 idle after reset",
            {busy, desc_req, burst_valid}, 0);

        // vector table
        foreach (VECS[v]) begin
            clear_tbl();
            tbl[0] = {VECS[v].c0, 32'h2000_0000};
            tbl[1] = {VECS[v].c1, 32'h2001_0000};
            tbl[2] = {VECS[v].c2, 32'h2002_0000};
            run_walk(int'(VECS[v].len), 1'b1, VECS[v].dir, VECS[v].res, 1'b0);
            if (v == 1) chk(b_len[0] == 17'd256, "R2 count bit 0 ignored", b_len[0], 256);
            if (v == 2) chk(nf == 2, "R7 stops after final entry", nf, 2);
            if (v == 3) chk(b_len[0] == 17'h10000, "R3 zero count is 64 KiB", b_len[0], 17'h10000);
            if (v == 4) chk(nf == 2, "R9 no read past satisfied data", nf, 2);
        end

        // R5: resume continues inside a partly used region
        clear_tbl();
        tbl[0] = {32'h0000_0200, 32'h3000_0000};
        tbl[1] = {32'h8000_0100, 32'h3100_0000};
        run_walk(100, 1'b1, 1'b1, 2'd0, 1'b0);
        run_walk(500, 1'b0, 1'b1, 2'd0, 1'b0);
        chk(b_addr[0] == 32'h3000_0064 && b_len[0] == 17'd412, "R5 resume mid-region",
            b_addr[0], 32'h3000_0064);
        chk(nf == 1 && f_log[0] == TBASE + 8, "R5 resume read pointer", f_log[0], TBASE + 8);
        run_walk(1000, 1'b0, 1'b0, 2'd1, 1'b0);
        chk(nb == 1 && b_len[0] == 17'd168, "R7 tail of final region", b_len[0], 168);

        // R8: table with no final flag, capped at one page
        clear_tbl();
        for (int i = 0; i < 512; i++) tbl[i] = {32'h0000_0002, 32'h4000_0000 + 32'(i * 16)};
        run_walk(2000, 1'b1, 1'b1, 2'd1, 1'b0);
        chk(nf == 512, "R8 page cap entry count", nf, 512);

        // R10: withdraw active after the first burst
        clear_tbl();
        for (int i = 0; i < 8; i++) tbl[i] = {32'h0000_0100, 32'h5000_0000 + 32'(i * 256)};
        run_walk(1000, 1'b1, 1'b0, 2'd2, 1'b1);
        chk(nb == 1 && nf == 1, "R10 no access after stop", nb * 16 + nf, 17);
        active = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule